// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides how the instruction pointer (IP) and the privilege word (PR) change when control enters or leaves an interrupt handler. It serves two kinds of entry. A hardware interrupt request arrives with a handler vector. A software interrupt call arrives with a target pointer and the address of the following instruction. Each kind has its own return strobe. The core presents its current IP and PR every cycle. The block answers with a one-cycle write of a new IP and a new PR. For a software call it also writes two general registers: R0 receives the saved privilege word and R1 receives the return pointer.

Hardware entries keep their saved IP and PR in two private context registers inside the block. They cannot nest: a hardware request that arrives while a hardware handler is running waits until that handler returns. Software entries keep no private state. The handler gets its saved context in R0 and R1, and the software return hands that context back through the r0/r1 inputs.

Top module: `irq_seq`

## Requirements
- R1: A strobe sampled at a clock edge produces its outputs in the cycle after that edge, as a single-cycle pulse on the write enables. After reset every write enable, the error flag and `hw_busy_o` are 0.
- R2: Taking a hardware interrupt writes IP = the request vector and PR = all ones, and `hw_busy_o` goes to 1 in the same cycle.
- R3: Taking a hardware interrupt captures `cur_ip_i` and `cur_pr_i` from the take cycle into internal old-IP and old-PR registers.
- R4: A hardware return while `hw_busy_o` is 1 writes IP = old IP and PR = old PR, and clears `hw_busy_o` in the same cycle.
- R5: A hardware request seen while `hw_busy_o` is 1 produces no write and is held pending. It is taken with its own vector one cycle after the outputs of the hardware return.
- R6: A hardware return while `hw_busy_o` is 0 pulses `hret_err_o` for one cycle, writes no IP or PR, and leaves `hw_busy_o` and the saved context unchanged.
- R7: A software call writes IP = target and PR = all ones. It writes R0 = the `cur_pr_i` value from the call cycle and R1 = the next-instruction pointer. `hw_busy_o` does not change.
- R8: A software return writes PR = `sret_pr_i` and IP = `sret_ip_i`, and writes neither R0 nor R1.
- R9: When a hardware interrupt is taken in the same cycle as a software call, the hardware entry is output first. The software call follows one cycle later, using the target, next pointer and PR sampled in the strobe cycle.
- R10: A software return that coincides with a hardware take is deferred in the same way. It appears one cycle after the hardware entry, with its r0/r1 values sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_ip_i | input | AW | Current instruction pointer |
| cur_pr_i | input | PW | Current privilege word |
| irq_req_i | input | 1 | Hardware interrupt request strobe |
| irq_vec_i | input | AW | Handler vector for the request |
| hret_i | input | 1 | Hardware-interrupt return strobe |
| swi_call_i | input | 1 | Software interrupt call strobe |
| swi_tgt_i | input | AW | Software handler target |
| swi_next_i | input | AW | Pointer to the instruction after the call |
| sret_i | input | 1 | Software-interrupt return strobe |
| sret_pr_i | input | PW | Current R0 contents (PR to restore) |
| sret_ip_i | input | AW | Current R1 contents (return pointer) |
| ip_we_o | output | 1 | IP write enable |
| ip_o | output | AW | New IP |
| pr_we_o | output | 1 | PR write enable |
| pr_o | output | PW | New PR |
| r0_we_o | output | 1 | R0 write enable |
| r0_o | output | PW | Value for R0 |
| r1_we_o | output | 1 | R1 write enable |
| r1_o | output | AW | Value for R1 |
| hw_busy_o | output | 1 | Hardware handler active |
| hret_err_o | output | 1 | Hardware return with no active handler |

## Verification
A corrupted old-IP or old-PR register stays hidden until the matching hardware return. At that point it shows up as a wrong IP or PR on the return write. The bench therefore changes `cur_ip_i` and `cur_pr_i` after every take and checks the return values against the take-cycle values. A stuck busy or pending flag shows up in one of two ways: a pending request that is never taken one cycle after the return, or a nested take while `hw_busy_o` is 1. A lost or mis-captured deferred software operation shows up on the cycle right after a collision, as a missing R0/R1 write or as values taken from the wrong cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_HTAKE,
    EV_HRET,
    EV_SCALL,
    EV_SRET
  } ev_e;

  typedef enum logic {
    SW_CALL,
    SW_RET
  } sw_kind_e;
endpackage

// File: rtl/irq_hw_ctx.sv
module irq_hw_ctx #(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_req_i,
  input  logic [AW-1:0] irq_vec_i,
  input  logic          hret_i,
  input  logic [AW-1:0] cur_ip_i,
  input  logic [PW-1:0] cur_pr_i,
  output logic          take_o,
  output logic [AW-1:0] take_vec_o,
  output logic          ret_ok_o,
  output logic          ret_bad_o,
  output logic [AW-1:0] oip_o,
  output logic [PW-1:0] opr_o,
  output logic          busy_o
);
  logic          busy_q, pend_q;
  logic [AW-1:0] oip_q, pend_vec_q;
  logic [PW-1:0] opr_q;

  assign take_o     = !busy_q && (pend_q || irq_req_i);
  assign take_vec_o = pend_q ? pend_vec_q : irq_vec_i;
  assign ret_ok_o   = hret_i && busy_q;
  assign ret_bad_o  = hret_i && !busy_q;
  assign oip_o      = oip_q;
  assign opr_o      = opr_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      oip_q  <= '0;
      opr_q  <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      oip_q  <= cur_ip_i;
      opr_q  <= cur_pr_i;
    end else if (ret_ok_o) begin
      busy_q <= 1'b0;
    end
  end

  // first request seen during a handler is kept; later ones merge into it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_vec_q <= '0;
    end else if (take_o) begin
      pend_q <= 1'b0;
    end else if (irq_req_i && !pend_q) begin
      pend_q     <= 1'b1;
      pend_vec_q <= irq_vec_i;
    end
  end

  AST_TAKE_SAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> busy_q && oip_q == $past(cur_ip_i) && opr_q == $past(cur_pr_i)); // R3
  AST_NO_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !hret_i |=> busy_q && $stable(oip_q) && $stable(opr_q)); // R5
  AST_REQ_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && irq_req_i |=> pend_q); // R5
  AST_BAD_RET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_bad_o && !take_o |=> !busy_q && $stable(oip_q) && $stable(opr_q)); // R6
endmodule

// File: rtl/irq_sw_ctx.sv
module irq_sw_ctx
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [AW-1:0] call_tgt_i,
  input  logic [AW-1:0] call_next_i,
  input  logic          ret_i,
  input  logic [PW-1:0] ret_pr_i,
  input  logic [AW-1:0] ret_ip_i,
  input  logic [PW-1:0] cur_pr_i,
  input  logic          hold_i,
  output logic          exec_call_o,
  output logic          exec_ret_o,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] next_o,
  output logic [PW-1:0] pr_o
);
  logic          def_q;
  sw_kind_e      def_kind_q;
  logic [AW-1:0] def_ip_q, def_next_q;
  logic [PW-1:0] def_pr_q;

  logic          act;
  sw_kind_e      act_kind;
  logic [AW-1:0] act_ip, act_next;
  logic [PW-1:0] act_pr;

  // a held operation outranks any live strobe
  always_comb begin
    if (def_q) begin
      act      = 1'b1;
      act_kind = def_kind_q;
      act_ip   = def_ip_q;
      act_next = def_next_q;
      act_pr   = def_pr_q;
    end else begin
      act      = call_i || ret_i;
      act_kind = call_i ? SW_CALL : SW_RET;
      act_ip   = call_i ? call_tgt_i : ret_ip_i;
      act_next = call_next_i;
      act_pr   = call_i ? cur_pr_i : ret_pr_i;
    end
  end

  assign exec_call_o = act && !hold_i && act_kind == SW_CALL;
  assign exec_ret_o  = act && !hold_i && act_kind == SW_RET;
  assign ip_o        = act_ip;
  assign next_o      = act_next;
  assign pr_o        = act_pr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      def_q      <= 1'b0;
      def_kind_q <= SW_CALL;
      def_ip_q   <= '0;
      def_next_q <= '0;
      def_pr_q   <= '0;
    end else if (act && hold_i) begin
      def_q      <= 1'b1;
      def_kind_q <= act_kind;
      def_ip_q   <= act_ip;
      def_next_q <= act_next;
      def_pr_q   <= act_pr;
    end else begin
      def_q <= 1'b0;
    end
  end

  AST_DEFER_ON_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && (call_i || ret_i) |=> def_q); // R9
  AST_DEFER_KEEPS_PR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !def_q && call_i |=> def_pr_q == $past(cur_pr_i)); // R9
  AST_DEFER_RET_VALS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !def_q && ret_i && !call_i |=> def_ip_q == $past(ret_ip_i)); // R10
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ev_e           ev_i,
  input  logic          err_i,
  input  logic [AW-1:0] hvec_i,
  input  logic [AW-1:0] oip_i,
  input  logic [PW-1:0] opr_i,
  input  logic [AW-1:0] sw_ip_i,
  input  logic [AW-1:0] sw_next_i,
  input  logic [PW-1:0] sw_pr_i,
  output logic          ip_we_o,
  output logic [AW-1:0] ip_o,
  output logic          pr_we_o,
  output logic [PW-1:0] pr_o,
  output logic          r0_we_o,
  output logic [PW-1:0] r0_o,
  output logic          r1_we_o,
  output logic [AW-1:0] r1_o,
  output logic          err_o
);
  localparam logic [PW-1:0] PrAll = {PW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_we_o <= 1'b0;
      ip_o    <= '0;
      pr_we_o <= 1'b0;
      pr_o    <= '0;
      r0_we_o <= 1'b0;
      r0_o    <= '0;
      r1_we_o <= 1'b0;
      r1_o    <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o   <= err_i;
      ip_we_o <= ev_i != EV_NONE;
      pr_we_o <= ev_i != EV_NONE;
      r0_we_o <= ev_i == EV_SCALL;
      r1_we_o <= ev_i == EV_SCALL;
      case (ev_i)
        EV_HTAKE: begin
          ip_o <= hvec_i;
          pr_o <= PrAll;
        end
        EV_HRET: begin
          ip_o <= oip_i;
          pr_o <= opr_i;
        end
        EV_SCALL: begin
          ip_o <= sw_ip_i;
          pr_o <= PrAll;
          r0_o <= sw_pr_i;
          r1_o <= sw_next_i;
        end
        EV_SRET: begin
          ip_o <= sw_ip_i;
          pr_o <= sw_pr_i;
        end
        default: ;
      endcase
    end
  end

  AST_ENTRY_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r0_we_o |-> r1_we_o && pr_we_o && pr_o == PrAll); // R7
  AST_IP_PR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_we_o == pr_we_o); // R1
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cur_ip_i,
  input  logic [PW-1:0] cur_pr_i,
  input  logic          irq_req_i,
  input  logic [AW-1:0] irq_vec_i,
  input  logic          hret_i,
  input  logic          swi_call_i,
  input  logic [AW-1:0] swi_tgt_i,
  input  logic [AW-1:0] swi_next_i,
  input  logic          sret_i,
  input  logic [PW-1:0] sret_pr_i,
  input  logic [AW-1:0] sret_ip_i,
  output logic          ip_we_o,
  output logic [AW-1:0] ip_o,
  output logic          pr_we_o,
  output logic [PW-1:0] pr_o,
  output logic          r0_we_o,
  output logic [PW-1:0] r0_o,
  output logic          r1_we_o,
  output logic [AW-1:0] r1_o,
  output logic          hw_busy_o,
  output logic          hret_err_o
);
  logic          take, ret_ok, ret_bad, busy;
  logic [AW-1:0] take_vec, oip;
  logic [PW-1:0] opr;
  logic          exec_call, exec_ret;
  logic [AW-1:0] sw_ip, sw_next;
  logic [PW-1:0] sw_pr;
  ev_e           ev;

  irq_hw_ctx #(.AW(AW), .PW(PW)) u_hw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_req_i  (irq_req_i),
    .irq_vec_i  (irq_vec_i),
    .hret_i     (hret_i),
    .cur_ip_i   (cur_ip_i),
    .cur_pr_i   (cur_pr_i),
    .take_o     (take),
    .take_vec_o (take_vec),
    .ret_ok_o   (ret_ok),
    .ret_bad_o  (ret_bad),
    .oip_o      (oip),
    .opr_o      (opr),
    .busy_o     (busy)
  );

  irq_sw_ctx #(.AW(AW), .PW(PW)) u_sw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (swi_call_i),
    .call_tgt_i  (swi_tgt_i),
    .call_next_i (swi_next_i),
    .ret_i       (sret_i),
    .ret_pr_i    (sret_pr_i),
    .ret_ip_i    (sret_ip_i),
    .cur_pr_i    (cur_pr_i),
    .hold_i      (take || ret_ok),
    .exec_call_o (exec_call),
    .exec_ret_o  (exec_ret),
    .ip_o        (sw_ip),
    .next_o      (sw_next),
    .pr_o        (sw_pr)
  );

  // hardware events own the output path; software waits one cycle
  always_comb begin
    if (ret_ok)         ev = EV_HRET;
    else if (take)      ev = EV_HTAKE;
    else if (exec_call) ev = EV_SCALL;
    else if (exec_ret)  ev = EV_SRET;
    else                ev = EV_NONE;
  end

  irq_out_stage #(.AW(AW), .PW(PW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .err_i     (ret_bad),
    .hvec_i    (take_vec),
    .oip_i     (oip),
    .opr_i     (opr),
    .sw_ip_i   (sw_ip),
    .sw_next_i (sw_next),
    .sw_pr_i   (sw_pr),
    .ip_we_o   (ip_we_o),
    .ip_o      (ip_o),
    .pr_we_o   (pr_we_o),
    .pr_o      (pr_o),
    .r0_we_o   (r0_we_o),
    .r0_o      (r0_o),
    .r1_we_o   (r1_we_o),
    .r1_o      (r1_o),
    .err_o     (hret_err_o)
  );

  assign hw_busy_o = busy;

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take, ret_ok, exec_call, exec_ret})); // R9
  AST_BAD_RET_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hret_i && !hw_busy_o |=> hret_err_o); // R6
  AST_TAKE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_busy_o && irq_req_i |=> hw_busy_o && ip_we_o && pr_o == {PW{1'b1}}); // R2
  AST_RET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hret_i && hw_busy_o |=> !hw_busy_o && ip_we_o); // R4
endmodule

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;
  localparam int AW = 32;
  localparam int PW = 32;
  localparam logic [PW-1:0] ONES = {PW{1'b1}};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] cur_ip_i = '0;
  logic [PW-1:0] cur_pr_i = '0;
  logic          irq_req_i = 1'b0;
  logic [AW-1:0] irq_vec_i = '0;
  logic          hret_i = 1'b0;
  logic          swi_call_i = 1'b0;
  logic [AW-1:0] swi_tgt_i = '0;
  logic [AW-1:0] swi_next_i = '0;
  logic          sret_i = 1'b0;
  logic [PW-1:0] sret_pr_i = '0;
  logic [AW-1:0] sret_ip_i = '0;
  logic          ip_we_o, pr_we_o, r0_we_o, r1_we_o, hw_busy_o, hret_err_o;
  logic [AW-1:0] ip_o, r1_o;
  logic [PW-1:0] pr_o, r0_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_seq #(.AW(AW), .PW(PW)) dut (.*);

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic clear_strobes();
    irq_req_i = 0; hret_i = 0; swi_call_i = 0; sret_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset ip_we", ip_we_o, 0);
    chk("R1 reset pr_we", pr_we_o, 0);
    chk("R1 reset r0_we", r0_we_o, 0);
    chk("R1 reset busy", hw_busy_o, 0);
    chk("R1 reset err", hret_err_o, 0);
  endtask

  task automatic t_hw_basic();
    cur_ip_i = 32'h1000; cur_pr_i = 32'hF0;
    irq_req_i = 1; irq_vec_i = 32'h8000;
    tick(); clear_strobes();
    chk("R2 ip_we", ip_we_o, 1);
    chk("R2 ip", ip_o, 32'h8000);
    chk("R2 pr", pr_o, ONES);
    chk("R2 busy", hw_busy_o, 1);
    cur_ip_i = 32'h8000; cur_pr_i = ONES;
    tick();
    chk("R1 pulse ends", ip_we_o, 0);
    hret_i = 1;
    tick(); clear_strobes();
    chk("R4 ip_we", ip_we_o, 1);
    chk("R3 ip restored", ip_o, 32'h1000);
    chk("R3 pr restored", pr_o, 32'hF0);
    chk("R4 busy clear", hw_busy_o, 0);
    tick();
  endtask

  task automatic t_pending();
    cur_ip_i = 32'h2000; cur_pr_i = 32'h3;
    irq_req_i = 1; irq_vec_i = 32'h8800;
    tick(); clear_strobes();
    chk("R2 ip second", ip_o, 32'h8800);
    cur_ip_i = 32'hAAAA; cur_pr_i = ONES;
    irq_req_i = 1; irq_vec_i = 32'h9000;
    tick(); clear_strobes();
    chk("R5 no nested write", ip_we_o, 0);
    chk("R5 still busy", hw_busy_o, 1);
    tick();
    hret_i = 1;
    tick(); clear_strobes();
    chk("R4 ret ip", ip_o, 32'h2000);
    chk("R4 ret pr", pr_o, 32'h3);
    chk("R4 busy clear", hw_busy_o, 0);
    cur_ip_i = 32'h2000; cur_pr_i = 32'h3;
    tick();
    chk("R5 pending taken", ip_we_o, 1);
    chk("R5 pending vec", ip_o, 32'h9000);
    chk("R5 pending pr", pr_o, ONES);
    chk("R5 busy again", hw_busy_o, 1);
    cur_ip_i = 32'h9000; cur_pr_i = ONES;
    hret_i = 1;
    tick(); clear_strobes();
    chk("R3 saved at take", ip_o, 32'h2000);
    chk("R3 saved pr at take", pr_o, 32'h3);
    tick();
    chk("R5 nothing further", ip_we_o, 0);
  endtask

  task automatic t_bad_hret();
    hret_i = 1;
    tick(); clear_strobes();
    chk("R6 err", hret_err_o, 1);
    chk("R6 no ip", ip_we_o, 0);
    chk("R6 no pr", pr_we_o, 0);
    chk("R6 busy", hw_busy_o, 0);
    tick();
    chk("R6 err pulse", hret_err_o, 0);
  endtask

  task automatic t_swi();
    cur_ip_i = 32'h100; cur_pr_i = 32'h55;
    swi_call_i = 1; swi_tgt_i = 32'h4000; swi_next_i = 32'h104;
    tick(); clear_strobes();
    chk("R7 ip", ip_o, 32'h4000);
    chk("R7 pr", pr_o, ONES);
    chk("R7 r0_we", r0_we_o, 1);
    chk("R7 r0", r0_o, 32'h55);
    chk("R7 r1_we", r1_we_o, 1);
    chk("R7 r1", r1_o, 32'h104);
    chk("R7 busy", hw_busy_o, 0);
    cur_pr_i = ONES;
    sret_i = 1; sret_pr_i = 32'h55; sret_ip_i = 32'h104;
    tick(); clear_strobes();
    chk("R8 ip", ip_o, 32'h104);
    chk("R8 pr", pr_o, 32'h55);
    chk("R8 pr_we", pr_we_o, 1);
    chk("R8 no r0", r0_we_o, 0);
    chk("R8 no r1", r1_we_o, 0);
    tick();
  endtask

  task automatic t_collide_call();
    cur_ip_i = 32'h300; cur_pr_i = 32'h7;
    irq_req_i = 1; irq_vec_i = 32'hB000;
    swi_call_i = 1; swi_tgt_i = 32'h5000; swi_next_i = 32'h304;
    tick(); clear_strobes();
    chk("R9 hw first ip", ip_o, 32'hB000);
    chk("R9 hw first no r0", r0_we_o, 0);
    chk("R9 busy", hw_busy_o, 1);
    cur_ip_i = 32'hB000; cur_pr_i = ONES;
    swi_tgt_i = 0; swi_next_i = 0;
    tick();
    chk("R9 call ip", ip_o, 32'h5000);
    chk("R9 call r0", r0_o, 32'h7);
    chk("R9 call r1", r1_o, 32'h304);
    chk("R9 call r0_we", r0_we_o, 1);
    hret_i = 1;
    tick(); clear_strobes();
    chk("R9 hw ret ip", ip_o, 32'h300);
    chk("R9 hw ret pr", pr_o, 32'h7);
    tick();
  endtask

  task automatic t_collide_ret();
    cur_ip_i = 32'h600; cur_pr_i = 32'h9;
    irq_req_i = 1; irq_vec_i = 32'hC000;
    sret_i = 1; sret_pr_i = 32'h11; sret_ip_i = 32'h700;
    tick(); clear_strobes();
    chk("R10 hw first ip", ip_o, 32'hC000);
    sret_pr_i = 0; sret_ip_i = 0;
    tick();
    chk("R10 ret ip", ip_o, 32'h700);
    chk("R10 ret pr", pr_o, 32'h11);
    chk("R10 no r0", r0_we_o, 0);
    hret_i = 1;
    tick(); clear_strobes();
    chk("R10 hw ret ip", ip_o, 32'h600);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    t_reset();
    t_hw_basic();
    t_pending();
    t_bad_hret();
    t_swi();
    t_collide_call();
    t_collide_ret();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule